// File: doc/BRIEF.md
# Rule 30 Ring Random Word Generator

This block keeps a ring of cells, one bit each, and advances every cell at the same clock edge under the elementary Rule 30. A cell's next bit is the exclusive OR of its west neighbour with the OR of itself and its east neighbour. The full cell vector is the output and serves as a pseudorandom word. Each cell reads only its two adjacent cells, so all routing stays local and the critical path is a single two-gate function, whatever the width.

The ring is built from `SEG_N` identical segments of `SEG_W` cells, placed in series. Each segment passes its edge cells to its neighbours, and the last segment closes the ring back onto the first. The result behaves as one cyclic array of `SEG_W*SEG_N` cells. West means the next lower index and east the next higher index, both taken modulo the total width. A synchronous load writes a seed. An enable decides whether the ring steps or holds.

Top module: `ca30_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes `RST_VAL` (default: only bit 0 set). Reset wins over `load` and `en`.
- R2: When `load` is high at a rising edge and `rst` is low, the state takes the value of `seed`.
- R3: When `load` and `en` are both high, the seed is loaded and no Rule 30 step takes place.
- R4: When `rst`, `load` and `en` are all low, the state keeps its value.
- R5: When only `en` is high, every bit i becomes s[i-1] XOR (s[i] OR s[i+1]), using the state from before the edge.
- R6: Indices wrap around the ring. The west neighbour of bit 0 is bit TOTAL-1, and the east neighbour of bit TOTAL-1 is bit 0.
- R7: Cells on either side of a segment boundary use each other as neighbours, exactly as cells inside a segment do.
- R8: An all-zero state stays all-zero while stepping.
- R9: An all-ones state becomes all-zero after one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Write `seed` into the ring |
| seed | input | SEG_W*SEG_N | Seed value |
| en | input | 1 | Advance the ring one Rule 30 step |
| state_o | output | SEG_W*SEG_N | Registered cell vector |

## Verification
The bench builds the block with `SEG_W=5` and `SEG_N=3`, which gives a 15-cell ring. This width is neither a power of two nor a single segment, so two interior segment boundaries and the ring closure are all present and sit at different positions. With single-bit seeds at bit 0, bit 4, bit 5 and bit 14, each junction can be checked against an expected triple of set bits. Long runs from several seeds are then compared step by step with a modulo-indexed model of the ring.

// File: rtl/ca30_pkg.sv
package ca30_pkg;
  // Rule 30 next-state function for one cell.
  function automatic logic rule30_next(input logic west, input logic self_bit, input logic east);
    return west ^ (self_bit | east);
  endfunction
endpackage

// File: rtl/ca30_cell.sv
module ca30_cell
  import ca30_pkg::*;
#(
  parameter logic RST_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic en,
  input  logic seed_bit,
  input  logic west,
  input  logic east,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= RST_BIT;
    else if (load) q <= seed_bit;
    else if (en)   q <= rule30_next(west, q, east);
  end
endmodule

// File: rtl/ca30_seg.sv
module ca30_seg #(
  parameter int              SEG_W   = 8,
  parameter logic [SEG_W-1:0] RST_SEG = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             en,
  input  logic [SEG_W-1:0] seed,
  input  logic             west_in,
  input  logic             east_in,
  output logic [SEG_W-1:0] q
);
  localparam int EXT_W = SEG_W + 2;

  // ext[0] is the outer west bit, ext[SEG_W+1] the outer east bit.
  logic [EXT_W-1:0] ext;
  assign ext = {east_in, q, west_in};

  for (genvar i = 0; i < SEG_W; i++) begin : g_cell
    ca30_cell #(.RST_BIT(RST_SEG[i])) u_cell (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .en      (en),
      .seed_bit(seed[i]),
      .west    (ext[i]),
      .east    (ext[i+2]),
      .q       (q[i])
    );
  end
endmodule

// File: rtl/ca30_gen.sv
module ca30_gen #(
  parameter int                     SEG_W   = 8,
  parameter int                     SEG_N   = 2,
  parameter logic [SEG_W*SEG_N-1:0] RST_VAL = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [SEG_W*SEG_N-1:0]   seed,
  input  logic                     en,
  output logic [SEG_W*SEG_N-1:0]   state_o
);
  localparam int TOTAL = SEG_W * SEG_N;

  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    localparam int LO = s * SEG_W;
    localparam int WI = (s == 0) ? TOTAL - 1 : LO - 1;
    localparam int EI = (s == SEG_N - 1) ? 0 : LO + SEG_W;

    ca30_seg #(
      .SEG_W  (SEG_W),
      .RST_SEG(RST_VAL[LO +: SEG_W])
    ) u_seg (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .en     (en),
      .seed   (seed[LO +: SEG_W]),
      .west_in(state_o[WI]),
      .east_in(state_o[EI]),
      .q      (state_o[LO +: SEG_W])
    );
  end
endmodule

// File: rtl/ca30_gen_chk.sv
module ca30_gen_chk #(
  parameter int TOTAL = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             en,
  input logic [TOTAL-1:0] seed,
  input logic [TOTAL-1:0] state
);
  // R2
  a_r2_load_seed: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(seed));

  // R3
  a_r3_load_over_step: assert property (@(posedge clk) disable iff (rst)
    (load && en) |=> state == $past(seed));

  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(state));

  // R8
  a_r8_zero_fixed: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state == '0) |=> state == '0);

  // R9
  a_r9_ones_clear: assert property (@(posedge clk) disable iff (rst)
    (en && !load && (&state)) |=> state == '0);
endmodule

bind ca30_gen ca30_gen_chk #(.TOTAL(TOTAL)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .load (load),
  .en   (en),
  .seed (seed),
  .state(state_o)
);

// File: tb/ca30_gen_test.sv
module ca30_gen_test;
  localparam int SW = 5;
  localparam int SN = 3;
  localparam int T  = SW * SN;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic         en = 1'b0;
  logic [T-1:0] seed = '0;
  logic [T-1:0] state_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ca30_gen #(.SEG_W(SW), .SEG_N(SN), .RST_VAL(15'h0001)) uut (
    .clk(clk), .rst(rst), .load(load), .seed(seed), .en(en), .state_o(state_o)
  );

  function automatic logic [T-1:0] ref_step(input logic [T-1:0] s);
    logic [T-1:0] n;
    for (int i = 0; i < T; i++)
      n[i] = s[(i + T - 1) % T] ^ (s[i] | s[(i + 1) % T]);
    return n;
  endfunction

  task automatic check(input string req, input logic [T-1:0] act, input logic [T-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [T-1:0] v);
    load = 1'b1; en = 1'b0; seed = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; load = 1'b1; en = 1'b1; seed = 15'h7abc;
    @(negedge clk); @(negedge clk);
    check("R1 reset value, reset over load/en", state_o, 15'h0001);
    rst = 1'b0; load = 1'b0; en = 1'b0;
  endtask

  task automatic t_load;
    do_load(15'h2d5a);
    check("R2 seed load", state_o, 15'h2d5a);
    do_load(15'h0001);
    check("R2 seed load", state_o, 15'h0001);
  endtask

  task automatic t_prio;
    do_load(15'h1234);
    load = 1'b1; en = 1'b1; seed = 15'h4321;
    @(negedge clk);
    load = 1'b0; en = 1'b0;
    check("R3 load wins over step", state_o, 15'h4321);
  endtask

  task automatic t_hold;
    do_load(15'h3c71);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R4 hold with enable low", state_o, 15'h3c71);
    end
  endtask

  task automatic t_run(input logic [T-1:0] s0, input int steps);
    logic [T-1:0] exp;
    do_load(s0);
    exp = s0;
    en = 1'b1;
    for (int k = 0; k < steps; k++) begin
      @(negedge clk);
      exp = ref_step(exp);
      check("R5 rule 30 step", state_o, exp);
    end
    en = 1'b0;
  endtask

  task automatic one_step(input string req, input logic [T-1:0] s0, input logic [T-1:0] exp);
    do_load(s0);
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    check(req, state_o, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    t_prio();
    t_hold();
    t_run(15'h0001, 40);
    t_run(15'h5a3c, 40);
    t_run(15'h7f00, 30);
    one_step("R6 wrap from bit 0", 15'h0001, 15'h4003);
    one_step("R6 wrap from bit 14", 15'h4000, 15'h6001);
    one_step("R7 boundary seg0 to seg1", 15'h0010, 15'h0038);
    one_step("R7 boundary seg1 to seg0", 15'h0020, 15'h0070);
    one_step("R7 boundary seg1 to seg2", 15'h0200, 15'h0700);
    one_step("R9 all ones clears", 15'h7fff, 15'h0000);
    do_load('0);
    en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 zero stays zero", state_o, 15'h0000);
    end
    en = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-run", state_o, 15'h0001);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule